// File: doc/BRIEF.md
# USB-C Source Attach and Orientation Controller

This block is the configuration-channel attach logic of a port that only sources power. External comparators classify each CC pin and present a 2-bit termination code per pin. The controller debounces both codes and accepts a sink when exactly one pin shows an Rd pull-down. That pin becomes the communication line, and its position gives the plug orientation. The controller then enables VBUS.

If the opposite pin shows an Ra load, the cable carries marker electronics. After orientation has been latched, the controller powers VCONN on that opposite pin. It then waits a programmable settle interval before it raises a flag that permits commands to the cable. When the communication pin reads open for the debounce period, the port returns to the unattached state and every output drops.

Top module: `usbc_src_attach`

## Requirements
- R1: After reset all outputs (attached_o, flipped_o, emarked_o, vbus_en_o, vconn_en_o, cable_cmd_ok_o) are 0.
- R2: Termination codes are 2'b00 open, 2'b01 Rd, 2'b10 Ra, and 2'b11 is treated as open. The first clock edge after a code pair is applied samples it. A pair with Rd on exactly one pin, held unchanged for debounce_cycles_i (at least 1) further edges, asserts vbus_en_o and attached_o on edge debounce_cycles_i+2.
- R3: At attach, flipped_o is 0 when Rd is on CC1 and 1 when Rd is on CC2.
- R4: If the non-Rd pin shows Ra at attach, emarked_o is 1. vconn_en_o becomes 2'b10 (CC2) for the unflipped case or 2'b01 (CC1) for the flipped case, one edge after vbus_en_o rises, and never earlier.
- R5: cable_cmd_ok_o rises settle_cycles_i+1 edges after vconn_en_o becomes nonzero.
- R6: Without Ra on the non-Rd pin, vconn_en_o stays 2'b00 and cable_cmd_ok_o stays 0 while attached.
- R7: Rd on both pins, Ra on both pins, or no Rd at all leaves the port unattached with VBUS and VCONN off.
- R8: A valid code pair held for only debounce_cycles_i edges before reverting to open never attaches.
- R9: When the communication pin reads open, all outputs return to 0 on edge debounce_cycles_i+2 after the change, and are still asserted one edge earlier.
- R10: The settle interval restarts from zero on every entry into the VCONN-powered state, so a reattach gives the same R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cc1_term_i | input | 2 | Termination code seen on CC1 |
| cc2_term_i | input | 2 | Termination code seen on CC2 |
| debounce_cycles_i | input | CNT_W | Edges a code pair must stay unchanged |
| settle_cycles_i | input | CNT_W | VCONN settle interval before cable commands |
| attached_o | output | 1 | Sink attached |
| flipped_o | output | 1 | Communication line is CC2 |
| emarked_o | output | 1 | Marked cable detected |
| vbus_en_o | output | 1 | VBUS switch enable |
| vconn_en_o | output | 2 | VCONN enable per pin, bit0 CC1, bit1 CC2 |
| cable_cmd_ok_o | output | 1 | Commands to the cable permitted |

## Verification
The assertions take for granted that both thresholds are held constant while the port is attached, and that the debounce threshold is at least one. The stimulus follows these rules. Each scenario draws fresh random thresholds and a random code pair from all four code values, but only while the port is unattached. Inputs are changed only between clock edges. The directed cases add short glitches, double-Rd and double-Ra pairs, and back-to-back reattaches that use the same settle interval.

// File: rtl/usbc_src_pkg.sv
`timescale 1ns/1ps
package usbc_src_pkg;
  typedef enum logic [1:0] {
    TERM_OPEN = 2'b00,
    TERM_RD   = 2'b01,
    TERM_RA   = 2'b10,
    TERM_RSVD = 2'b11
  } term_e;

  typedef enum logic [2:0] {
    ST_UNATTACHED,
    ST_ATTACH_WAIT,
    ST_ATTACHED,
    ST_VCONN_ON,
    ST_CABLE_READY
  } state_e;

  localparam int unsigned NUM_CC = 2;
endpackage

// File: rtl/cc_debounce.sv
`timescale 1ns/1ps
module cc_debounce #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cc1_i,
  input  logic [1:0]       cc2_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [1:0]       cc1_o,
  output logic [1:0]       cc2_o,
  output logic             stable_o
);
  import usbc_src_pkg::*;

  logic [NUM_CC-1:0][1:0] raw;
  logic [NUM_CC-1:0][1:0] samp_q;
  logic [NUM_CC-1:0]      pin_chg;
  logic [CNT_W-1:0]       cnt_q;
  logic                   any_chg;

  assign raw[0] = cc1_i;
  assign raw[1] = cc2_i;

  for (genvar p = 0; p < NUM_CC; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) samp_q[p] <= TERM_OPEN;
      else         samp_q[p] <= raw[p];
    end
    assign pin_chg[p] = (raw[p] != samp_q[p]);
  end

  assign any_chg = |pin_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (any_chg)           cnt_q <= '0;
    else if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign cc1_o    = samp_q[0];
  assign cc2_o    = samp_q[1];
  assign stable_o = (cnt_q >= limit_i);

  // R8: any code change restarts the stability window
  a_r8_change_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc1_i != cc1_o || cc2_i != cc2_o) |=> (cnt_q == '0));
endmodule

// File: rtl/term_classify.sv
`timescale 1ns/1ps
module term_classify (
  input  logic [1:0] cc1_i,
  input  logic [1:0] cc2_i,
  output logic       sink_valid_o,
  output logic       rd_on_cc2_o,
  output logic       ra_other_o,
  output logic       open1_o,
  output logic       open2_o
);
  import usbc_src_pkg::*;

  logic rd1, rd2, ra1, ra2;

  always_comb begin
    rd1 = (cc1_i == TERM_RD);
    rd2 = (cc2_i == TERM_RD);
    ra1 = (cc1_i == TERM_RA);
    ra2 = (cc2_i == TERM_RA);
    // reserved code reads as open
    open1_o      = (cc1_i == TERM_OPEN) || (cc1_i == TERM_RSVD);
    open2_o      = (cc2_i == TERM_OPEN) || (cc2_i == TERM_RSVD);
    sink_valid_o = rd1 ^ rd2;
    rd_on_cc2_o  = rd2;
    ra_other_o   = rd1 ? ra2 : ra1;
  end
endmodule

// File: rtl/attach_fsm.sv
`timescale 1ns/1ps
module attach_fsm #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stable_i,
  input  logic             sink_valid_i,
  input  logic             rd_on_cc2_i,
  input  logic             ra_other_i,
  input  logic             open1_i,
  input  logic             open2_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             attached_o,
  output logic             flipped_o,
  output logic             emarked_o,
  output logic             vbus_en_o,
  output logic [1:0]       vconn_en_o,
  output logic             cable_cmd_ok_o
);
  import usbc_src_pkg::*;

  state_e           state_q;
  logic             flip_q, emark_q;
  logic [CNT_W-1:0] settle_q;
  logic             comm_open, detach, vconn_on;

  assign comm_open = flip_q ? open2_i : open1_i;
  assign detach    = stable_i && comm_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_UNATTACHED;
      flip_q   <= 1'b0;
      emark_q  <= 1'b0;
      settle_q <= '0;
    end else begin
      unique case (state_q)
        ST_UNATTACHED: begin
          flip_q  <= 1'b0;
          emark_q <= 1'b0;
          if (sink_valid_i) state_q <= ST_ATTACH_WAIT;
        end
        ST_ATTACH_WAIT: begin
          if (!sink_valid_i) state_q <= ST_UNATTACHED;
          else if (stable_i) begin
            state_q <= ST_ATTACHED;
            flip_q  <= rd_on_cc2_i;
            emark_q <= ra_other_i;
          end
        end
        ST_ATTACHED: begin
          if (detach) state_q <= ST_UNATTACHED;
          else if (emark_q) begin
            state_q  <= ST_VCONN_ON;
            settle_q <= '0;
          end
        end
        ST_VCONN_ON: begin
          if (detach)                    state_q  <= ST_UNATTACHED;
          else if (settle_q >= settle_i) state_q  <= ST_CABLE_READY;
          else                           settle_q <= settle_q + 1'b1;
        end
        ST_CABLE_READY: begin
          if (detach) state_q <= ST_UNATTACHED;
        end
        default: state_q <= ST_UNATTACHED;
      endcase
    end
  end

  assign attached_o     = (state_q == ST_ATTACHED) || vconn_on || (state_q == ST_CABLE_READY);
  assign vconn_on       = (state_q == ST_VCONN_ON) || (state_q == ST_CABLE_READY);
  assign vbus_en_o      = attached_o;
  assign flipped_o      = attached_o && flip_q;
  assign emarked_o      = attached_o && emark_q;
  assign vconn_en_o     = vconn_on ? (flip_q ? 2'b01 : 2'b10) : 2'b00;
  assign cable_cmd_ok_o = (state_q == ST_CABLE_READY);

  // R2: VBUS only rises from a debounced valid sink
  a_r2_vbus_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vbus_en_o) |-> $past(state_q == ST_ATTACH_WAIT && stable_i && sink_valid_i));
  // R4: VCONN on at most one pin, only entered from the attached state
  a_r4_vconn_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vconn_en_o));
  a_r4_vconn_after_orient: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vconn_on) |-> $past(state_q == ST_ATTACHED));
  // R5: ready only after the settle window elapsed
  a_r5_ready_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cable_cmd_ok_o) |-> $past(state_q == ST_VCONN_ON && settle_q >= settle_i));
  // R6: no VCONN without a marked cable
  a_r6_no_vconn_unmarked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vconn_en_o != 2'b00) |-> emarked_o);
  // R9: detach drops every output on the next edge
  a_r9_detach_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detach && state_q != ST_UNATTACHED && state_q != ST_ATTACH_WAIT)
      |=> (!vbus_en_o && vconn_en_o == 2'b00 && !cable_cmd_ok_o));
  // R10: settle counter starts at zero on each entry
  a_r10_settle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vconn_on) |-> (settle_q == '0));
endmodule

// File: rtl/usbc_src_attach.sv
`timescale 1ns/1ps
module usbc_src_attach #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cc1_term_i,
  input  logic [1:0]       cc2_term_i,
  input  logic [CNT_W-1:0] debounce_cycles_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic             attached_o,
  output logic             flipped_o,
  output logic             emarked_o,
  output logic             vbus_en_o,
  output logic [1:0]       vconn_en_o,
  output logic             cable_cmd_ok_o
);
  logic [1:0] cc1_db, cc2_db;
  logic       stable, sink_valid, rd_on_cc2, ra_other, open1, open2;

  cc_debounce #(.CNT_W(CNT_W)) u_deb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cc1_i    (cc1_term_i),
    .cc2_i    (cc2_term_i),
    .limit_i  (debounce_cycles_i),
    .cc1_o    (cc1_db),
    .cc2_o    (cc2_db),
    .stable_o (stable)
  );

  term_classify u_cls (
    .cc1_i        (cc1_db),
    .cc2_i        (cc2_db),
    .sink_valid_o (sink_valid),
    .rd_on_cc2_o  (rd_on_cc2),
    .ra_other_o   (ra_other),
    .open1_o      (open1),
    .open2_o      (open2)
  );

  attach_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stable_i       (stable),
    .sink_valid_i   (sink_valid),
    .rd_on_cc2_i    (rd_on_cc2),
    .ra_other_i     (ra_other),
    .open1_i        (open1),
    .open2_i        (open2),
    .settle_i       (settle_cycles_i),
    .attached_o     (attached_o),
    .flipped_o      (flipped_o),
    .emarked_o      (emarked_o),
    .vbus_en_o      (vbus_en_o),
    .vconn_en_o     (vconn_en_o),
    .cable_cmd_ok_o (cable_cmd_ok_o)
  );
endmodule

// File: tb/usbc_src_attach_tb_top.sv
`timescale 1ns/1ps
module usbc_src_attach_tb_top;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cc1 = 2'b00, cc2 = 2'b00;
  logic [CNT_W-1:0] dbc = 16'd2, stl = 16'd3;
  logic             attached, flipped, emarked, vbus;
  logic [1:0]       vconn;
  logic             cable_ok;
  int               checks = 0, failures = 0;
  bit               done = 1'b0;
  int unsigned      seed_dummy;

  always #5 clk = ~clk;

  usbc_src_attach #(.CNT_W(CNT_W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .cc1_term_i (cc1), .cc2_term_i (cc2),
    .debounce_cycles_i (dbc), .settle_cycles_i (stl),
    .attached_o (attached), .flipped_o (flipped), .emarked_o (emarked),
    .vbus_en_o (vbus), .vconn_en_o (vconn), .cable_cmd_ok_o (cable_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit is_rd(input logic [1:0] c); return c == 2'b01; endfunction
  function automatic bit is_ra(input logic [1:0] c); return c == 2'b10; endfunction
  function automatic bit exp_valid(input logic [1:0] a, input logic [1:0] b);
    return is_rd(a) ^ is_rd(b);
  endfunction
  function automatic bit exp_emark(input logic [1:0] a, input logic [1:0] b);
    return is_rd(a) ? is_ra(b) : is_ra(a);
  endfunction
  function automatic logic [1:0] exp_vconn(input logic [1:0] a);
    return is_rd(a) ? 2'b10 : 2'b01;
  endfunction

  // full attach/detach sequence; port must be unattached on entry
  task automatic scenario(input logic [1:0] a, input logic [1:0] b,
                          input int n, input int s, input string ready_tag);
    bit v, e;
    v = exp_valid(a, b);
    e = exp_emark(a, b);
    dbc = n[CNT_W-1:0];
    stl = s[CNT_W-1:0];
    cc1 = a; cc2 = b;
    step(n + 1);
    chk("R2 vbus before debounce", vbus, 0);
    step(1);
    if (!v) begin
      chk("R7 unsupported stays off", vbus, 0);
      step(2 * n + 6);
      chk("R7 unsupported vbus", vbus, 0);
      chk("R7 unsupported vconn", vconn, 0);
    end else begin
      chk("R2 vbus at attach", vbus, 1);
      chk("R2 attached", attached, 1);
      chk("R3 orientation", flipped, is_rd(b));
      chk("R4 emarked flag", emarked, e);
      chk("R4 vconn not before orient", vconn, 0);
      step(1);
      if (e) begin
        chk("R4 vconn pin", vconn, exp_vconn(a));
        step(s);
        chk({ready_tag, " cable_ok early"}, cable_ok, 0);
        step(1);
        chk({ready_tag, " cable_ok on time"}, cable_ok, 1);
      end else begin
        chk("R6 vconn off unmarked", vconn, 0);
        step(s + 2);
        chk("R6 cable_ok off unmarked", cable_ok, 0);
      end
      // detach: communication pin goes open
      cc1 = 2'b00; cc2 = 2'b00;
      step(n + 1);
      chk("R9 vbus before detach done", vbus, 1);
      step(1);
      chk("R9 vbus off", vbus, 0);
      chk("R9 vconn off", vconn, 0);
      chk("R9 cable_ok off", cable_ok, 0);
      chk("R9 attached off", attached, 0);
    end
    cc1 = 2'b00; cc2 = 2'b00;
    step(n + 3);
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    step(3);
    chk("R1 vbus reset", vbus, 0);
    chk("R1 vconn reset", vconn, 0);
    chk("R1 cable_ok reset", cable_ok, 0);
    chk("R1 attached reset", attached + flipped + emarked, 0);
    rst_n = 1'b1;
    step(2);

    // directed
    scenario(2'b01, 2'b00, 2, 3, "R5");   // unflipped plain
    scenario(2'b00, 2'b01, 3, 0, "R5");   // flipped plain
    scenario(2'b01, 2'b10, 1, 4, "R5");   // unflipped marked
    scenario(2'b10, 2'b01, 4, 2, "R5");   // flipped marked
    scenario(2'b10, 2'b01, 4, 2, "R10");  // reattach, same settle timing
    scenario(2'b01, 2'b11, 2, 1, "R5");   // reserved reads open
    scenario(2'b01, 2'b01, 2, 1, "R7");
    scenario(2'b10, 2'b10, 2, 1, "R7");

    // R8: glitch held for exactly the debounce count
    dbc = 16'd5;
    cc1 = 2'b01; cc2 = 2'b00;
    step(5);
    cc1 = 2'b00;
    for (int i = 0; i < 14; i++) begin
      step(1);
      chk("R8 glitch ignored", vbus, 0);
    end

    // random
    for (int i = 0; i < 40; i++) begin
      int n, s;
      logic [1:0] a, b;
      n = 1 + int'($urandom_range(7));
      s = int'($urandom_range(9));
      a = 2'($urandom_range(3));
      b = 2'($urandom_range(3));
      scenario(a, b, n, s, "R5");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule